// File: doc/BRIEF.md
# Converter Protection and Auto-Restart Supervisor

This block is the sequencing and fault state machine of a switching-converter controller. It takes digitized comparator flags, a per-cycle end strobe and a thermal flag. From them it decides when the power switch may run and when the high-voltage start-up charger feeds the supply capacitor. It also reports whether soft-start is in progress and whether the feedback node must be clamped to its linear limit.

After power-up the block waits in undervoltage. It charges the supply only while the drain is high enough to start. It begins switching once the supply passes its turn-on level, and a start-up phase of fixed length then runs. During that phase the feedback clamp keeps overload from tripping. Overcurrent, overload, overvoltage and thermal faults lead to a latched stop that clears only when the supply falls below a low restart level. Charging then resumes at reduced current. Brown-out is a non-latched pause.

Top module: `prot_supervisor`

## Requirements
- R1: While reset is held, swEnable, chargerEn, chargerLowI, fbClamp and softStartActive are all 0, and the block leaves reset in the undervoltage state.
- R2: In undervoltage, a high supplyOn sampled at a clock edge starts switching from that edge, and chargerEn is 0 whenever swEnable is 1.
- R3: In undervoltage, chargerEn follows drainOk one clock later, so with drainOk low the block neither charges nor starts.
- R4: While switching, a high supplyLow stops switching at the next edge and returns the block to undervoltage with full-current charging (chargerLowI 0).
- R5: ocp2Trip is examined only at edges where cycleEnd is 1. A trip at one strobe arms a warning, a strobe without a trip clears it, and a trip at two consecutive strobes latches a fault that stops switching at that edge.
- R6: While a fault is latched, switching and charging stay off whatever supplyLow does. A high supplyRestart clears the latch into undervoltage with chargerEn 1 and chargerLowI 1, and chargerLowI drops when switching resumes.
- R7: Counting edges since switching began, softStartActive is 1 for the first SOFT_LEN cycles and fbClamp is 1 for the first START_LEN cycles (SOFT_LEN < START_LEN). Both are 0 when not switching.
- R8: overload has no effect while fbClamp is 1. Once the start-up phase has ended, overload latches a fault at the next edge.
- R9: While switching, ovpFault latches a fault at the next edge, on the same restart path as R6.
- R10: brownOut stops switching and charging without latching. Switching resumes at the edge after it clears, with no restart needed and the start-up phase count kept where it was.
- R11: thermal overrides every other input and holds switching and charging off until it clears. The block then enters the latched-fault state of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyOn | input | 1 | Supply above turn-on level |
| supplyLow | input | 1 | Supply below turn-off level |
| supplyRestart | input | 1 | Supply below restart level |
| drainOk | input | 1 | Drain voltage high enough to start |
| ocp2Trip | input | 1 | Second-level overcurrent seen this cycle |
| cycleEnd | input | 1 | End-of-switching-cycle strobe |
| overload | input | 1 | Feedback above overload level |
| ovpFault | input | 1 | Output overvoltage fault |
| brownOut | input | 1 | Input below brown-out level |
| thermal | input | 1 | Thermal shutdown active |
| swEnable | output | 1 | Power switch may run |
| chargerEn | output | 1 | Start-up charger on |
| chargerLowI | output | 1 | Charger in reduced-current mode |
| fbClamp | output | 1 | Feedback clamped to linear limit |
| softStartActive | output | 1 | Soft-start ramp in progress |

## Verification
The bench builds the block with START_LEN = 12 and SOFT_LEN = 5. At these values every cycle of the start-up phase can be walked and compared against the two window lengths. Overload can be held for the whole clamp window, and the edge where it finally counts is reachable in a few dozen cycles. All sixteen four-strobe overcurrent trip patterns are swept, each from a fresh power-up. The expected latch point for each pattern is the first pair of adjacent set bits.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [2:0] {
    ST_UVLO  = 3'd0,
    ST_RUN   = 3'd1,
    ST_BROWN = 3'd2,
    ST_FAULT = 3'd3,
    ST_THERM = 3'd4
  } supState_t;

  // control -> datapath
  typedef struct packed {
    logic clrPhase;
    logic runPhase;
    logic watchOcp;
  } supStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic phaseActive;
    logic softActive;
    logic ocpLatch;
    logic drainOkQ;
  } supStatus_t;

endpackage

// File: rtl/sup_timers.sv
module sup_timers
  import sup_pkg::*;
#(
  parameter int START_LEN = 1000000,
  parameter int SOFT_LEN  = 400000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       drainOk,
  input  logic       ocp2Trip,
  input  logic       cycleEnd,
  input  supStrobe_t strobe,
  output supStatus_t status
);

  localparam int CW = $clog2(START_LEN + 1);
  localparam logic [CW-1:0] START_CNT = CW'(START_LEN);
  localparam logic [CW-1:0] SOFT_CNT  = CW'(SOFT_LEN);

  logic [CW-1:0] phaseCnt;
  logic          ocpWarn;
  logic          drainQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      ocpWarn  <= 1'b0;
      drainQ   <= 1'b0;
    end else begin
      drainQ <= drainOk;
      // R7: start-up phase counter, frozen outside switching, saturating
      if (strobe.clrPhase)
        phaseCnt <= '0;
      else if (strobe.runPhase && (phaseCnt != START_CNT))
        phaseCnt <= phaseCnt + 1'b1;
      // R5: single-trip warning, refreshed only at cycle end
      if (!strobe.watchOcp)
        ocpWarn <= 1'b0;
      else if (cycleEnd)
        ocpWarn <= ocp2Trip;
    end
  end

  always_comb begin
    status.phaseActive = (phaseCnt < START_CNT);
    status.softActive  = (phaseCnt < SOFT_CNT);
    status.ocpLatch    = strobe.watchOcp && cycleEnd && ocp2Trip && ocpWarn;
    status.drainOkQ    = drainQ;
  end

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOn,
  input  logic       supplyLow,
  input  logic       supplyRestart,
  input  logic       overload,
  input  logic       ovpFault,
  input  logic       brownOut,
  input  logic       thermal,
  input  supStatus_t status,
  output supStrobe_t strobe,
  output logic       swEnable,
  output logic       chargerEn,
  output logic       chargerLowI,
  output logic       fbClamp,
  output logic       softStartActive
);

  supState_t state, nxtState;
  logic      lowMode, nxtLowMode;
  logic      latchFault;

  // R8/R9/R5: any latched fault while switching; overload masked by clamp
  assign latchFault = status.ocpLatch || ovpFault ||
                      (overload && !status.phaseActive);

  always_comb begin
    nxtState = state;
    if (thermal) begin
      nxtState = ST_THERM;                       // R11: highest priority
    end else begin
      unique case (state)
        ST_UVLO:  if (supplyOn) nxtState = ST_RUN;
        ST_RUN: begin
          if (supplyLow)       nxtState = ST_UVLO;
          else if (latchFault) nxtState = ST_FAULT;
          else if (brownOut)   nxtState = ST_BROWN;
        end
        ST_BROWN: begin
          if (supplyLow)       nxtState = ST_UVLO;
          else if (!brownOut)  nxtState = ST_RUN;
        end
        ST_FAULT: if (supplyRestart) nxtState = ST_UVLO;
        ST_THERM: nxtState = ST_FAULT;
        default:  nxtState = ST_UVLO;
      endcase
    end
  end

  always_comb begin
    nxtLowMode = lowMode;
    if (state == ST_FAULT && nxtState == ST_UVLO) nxtLowMode = 1'b1;
    else if (nxtState == ST_RUN)                  nxtLowMode = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_UVLO;
      lowMode <= 1'b0;
    end else begin
      state   <= nxtState;
      lowMode <= nxtLowMode;
    end
  end

  always_comb begin
    strobe.clrPhase = (state == ST_UVLO);
    strobe.runPhase = (state == ST_RUN);
    strobe.watchOcp = (state == ST_RUN);
  end

  always_comb begin
    swEnable        = (state == ST_RUN);
    chargerEn       = (state == ST_UVLO) && status.drainOkQ;
    chargerLowI     = chargerEn && lowMode;
    fbClamp         = swEnable && status.phaseActive;
    softStartActive = swEnable && status.softActive;
  end

endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import sup_pkg::*;
#(
  parameter int START_LEN = 1000000,
  parameter int SOFT_LEN  = 400000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOn,
  input  logic supplyLow,
  input  logic supplyRestart,
  input  logic drainOk,
  input  logic ocp2Trip,
  input  logic cycleEnd,
  input  logic overload,
  input  logic ovpFault,
  input  logic brownOut,
  input  logic thermal,
  output logic swEnable,
  output logic chargerEn,
  output logic chargerLowI,
  output logic fbClamp,
  output logic softStartActive
);

  supStrobe_t strobe;
  supStatus_t status;

  sup_timers #(.START_LEN(START_LEN), .SOFT_LEN(SOFT_LEN)) uTimers (
    .clk(clk), .rstN(rstN), .drainOk(drainOk), .ocp2Trip(ocp2Trip),
    .cycleEnd(cycleEnd), .strobe(strobe), .status(status)
  );

  sup_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .supplyOn(supplyOn), .supplyLow(supplyLow),
    .supplyRestart(supplyRestart), .overload(overload), .ovpFault(ovpFault),
    .brownOut(brownOut), .thermal(thermal), .status(status), .strobe(strobe),
    .swEnable(swEnable), .chargerEn(chargerEn), .chargerLowI(chargerLowI),
    .fbClamp(fbClamp), .softStartActive(softStartActive)
  );

endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk (
  input logic clk,
  input logic rstN,
  input logic supplyLow,
  input logic ovpFault,
  input logic thermal,
  input logic swEnable,
  input logic chargerEn,
  input logic chargerLowI,
  input logic fbClamp,
  input logic softStartActive
);

  a_r2_no_charge_while_switching: assert property (@(posedge clk) disable iff (!rstN)
    !(swEnable && chargerEn));

  a_r7_soft_inside_clamp: assert property (@(posedge clk) disable iff (!rstN)
    softStartActive |-> fbClamp);

  a_r7_clamp_needs_switching: assert property (@(posedge clk) disable iff (!rstN)
    fbClamp |-> swEnable);

  a_r4_supply_low_stops: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && supplyLow) |=> !swEnable);

  a_r9_ovp_stops: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && ovpFault) |=> !swEnable);

  a_r11_thermal_holds_off: assert property (@(posedge clk) disable iff (!rstN)
    thermal |=> (!swEnable && !chargerEn));

  a_r6_low_current_only_charging: assert property (@(posedge clk) disable iff (!rstN)
    chargerLowI |-> (chargerEn && !swEnable));

endmodule

bind prot_supervisor prot_supervisor_chk uChk (
  .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .ovpFault(ovpFault),
  .thermal(thermal), .swEnable(swEnable), .chargerEn(chargerEn),
  .chargerLowI(chargerLowI), .fbClamp(fbClamp),
  .softStartActive(softStartActive)
);

// File: tb/sim_prot_supervisor.sv
module sim_prot_supervisor;

  localparam int START_LEN = 12;
  localparam int SOFT_LEN  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOn = 0, supplyLow = 0, supplyRestart = 0, drainOk = 0;
  logic ocp2Trip = 0, cycleEnd = 0, overload = 0, ovpFault = 0;
  logic brownOut = 0, thermal = 0;
  logic swEnable, chargerEn, chargerLowI, fbClamp, softStartActive;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prot_supervisor #(.START_LEN(START_LEN), .SOFT_LEN(SOFT_LEN)) u0 (
    .clk(clk), .rstN(rstN), .supplyOn(supplyOn), .supplyLow(supplyLow),
    .supplyRestart(supplyRestart), .drainOk(drainOk), .ocp2Trip(ocp2Trip),
    .cycleEnd(cycleEnd), .overload(overload), .ovpFault(ovpFault),
    .brownOut(brownOut), .thermal(thermal), .swEnable(swEnable),
    .chargerEn(chargerEn), .chargerLowI(chargerLowI), .fbClamp(fbClamp),
    .softStartActive(softStartActive)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic powerUp();
    supplyOn = 1; step(); supplyOn = 0;
  endtask

  task automatic powerDown();
    supplyLow = 1; step(); supplyLow = 0;
  endtask

  task automatic restart();
    supplyRestart = 1; step(); supplyRestart = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    @(negedge clk);
    drainOk = 1; supplyOn = 1;
    step(); step();
    // R1: outputs inactive during reset regardless of inputs
    chk("R1", "swEnable in reset", swEnable, 1'b0);
    chk("R1", "chargerEn in reset", chargerEn, 1'b0);
    chk("R1", "chargerLowI in reset", chargerLowI, 1'b0);
    chk("R1", "fbClamp in reset", fbClamp, 1'b0);
    chk("R1", "softStart in reset", softStartActive, 1'b0);
    drainOk = 0; supplyOn = 0;
    rstN = 1;
    step(); step();
    // R3: no drain voltage -> no charging, no start
    chk("R3", "charger with drain low", chargerEn, 1'b0);
    chk("R3", "switching with drain low", swEnable, 1'b0);
    drainOk = 1; step();
    chk("R3", "charger one cycle after drainOk", chargerEn, 1'b1);
    chk("R3", "full current at first charge", chargerLowI, 1'b0);

    // R7 + R2: walk the whole start-up window
    powerUp();
    chk("R2", "switching after supplyOn", swEnable, 1'b1);
    chk("R2", "charger off while switching", chargerEn, 1'b0);
    for (int j = 0; j <= START_LEN + 2; j++) begin
      chk("R7", $sformatf("softStart at cycle %0d", j), softStartActive, 1'(j < SOFT_LEN));
      chk("R7", $sformatf("fbClamp at cycle %0d", j), fbClamp, 1'(j < START_LEN));
      step();
    end

    // R4: supply collapse
    powerDown();
    chk("R4", "switching after supplyLow", swEnable, 1'b0);
    chk("R4", "charger back on", chargerEn, 1'b1);
    chk("R4", "full current after normal power-down", chargerLowI, 1'b0);
    chk("R7", "fbClamp off when stopped", fbClamp, 1'b0);

    // R8: overload masked during clamp, acts afterwards
    powerUp();
    overload = 1;
    for (int j = 0; j < START_LEN; j++) step();
    chk("R8", "overload ignored during clamp", swEnable, 1'b1);
    step();
    chk("R8", "overload after clamp latches", swEnable, 1'b0);
    overload = 0;
    // R6: latched until restart level, supplyLow irrelevant
    supplyLow = 1;
    step(); step();
    chk("R6", "no switching while latched", swEnable, 1'b0);
    chk("R6", "no charging while latched", chargerEn, 1'b0);
    supplyLow = 0;
    restart();
    chk("R6", "charger on after restart level", chargerEn, 1'b1);
    chk("R6", "reduced current after fault", chargerLowI, 1'b1);
    powerUp();
    chk("R6", "reduced current cleared on run", chargerLowI, 1'b0);
    chk("R6", "switching after auto-restart", swEnable, 1'b1);

    // R9: overvoltage
    ovpFault = 1; step(); ovpFault = 0;
    chk("R9", "switching after ovp", swEnable, 1'b0);
    step();
    chk("R9", "still latched after ovp clears", swEnable, 1'b0);
    chk("R9", "charger off while latched", chargerEn, 1'b0);
    restart();
    chk("R9", "reduced current after ovp restart", chargerLowI, 1'b1);

    // R5: sweep all four-strobe trip patterns
    for (int p = 0; p < 16; p++) begin
      bit latched;
      latched = 0;
      powerUp();
      for (int i = 0; i < 4; i++) begin
        ocp2Trip = 1; cycleEnd = 0; step();  // trip without strobe: ignored
        ocp2Trip = p[i]; cycleEnd = 1; step();
        ocp2Trip = 0; cycleEnd = 0;
        if (i > 0 && p[i] && p[i-1]) latched = 1;
        chk("R5", $sformatf("pattern %0h strobe %0d switching", p, i), swEnable, !latched);
      end
      if (latched) restart(); else powerDown();
    end

    // R10: brown-out pause keeps phase count
    powerUp();
    step(); step(); step();
    brownOut = 1; step();
    chk("R10", "switching during brown-out", swEnable, 1'b0);
    chk("R10", "charger during brown-out", chargerEn, 1'b0);
    step(); step();
    brownOut = 0; step();
    chk("R10", "switching resumes after brown-out", swEnable, 1'b1);
    chk("R10", "soft-start count kept (cycle 4)", softStartActive, 1'b1);
    step();
    chk("R10", "soft-start ends at cycle 5", softStartActive, 1'b0);
    chk("R10", "clamp still active at cycle 5", fbClamp, 1'b1);

    // R11: thermal priority
    ovpFault = 1; thermal = 1; step(); ovpFault = 0;
    chk("R11", "switching with thermal", swEnable, 1'b0);
    supplyRestart = 1; step();
    chk("R11", "thermal holds charger off", chargerEn, 1'b0);
    thermal = 0; step();
    chk("R11", "latched fault after thermal clears", chargerEn, 1'b0);
    step();
    supplyRestart = 0;
    chk("R11", "restart path after thermal", chargerEn, 1'b1);
    chk("R11", "reduced current after thermal", chargerLowI, 1'b1);
    thermal = 1; supplyOn = 1; step(); supplyOn = 0;
    chk("R11", "thermal blocks start from undervoltage", swEnable, 1'b0);
    thermal = 0;

    finishRun();
  end

endmodule